// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides a fast system clock down to a serial bit rate that is not a whole fraction of it. It emits a one-clock tick at the start of each bit slot. The requested bit period is a whole part N plus a fraction num/den, both in clocks. Each slot lasts either N or N+1 clocks. A remainder accumulator picks between the two, so over every den slots exactly num of them are long. The average rate is therefore exact and never drifts.

The accumulator is seeded at half the denominator. This makes every tick land on the ideal tick time rounded to the nearest clock, with a fractional half rounded upward. As a result, long and short slots alternate as evenly as the fraction allows and are never bunched together. For example, 80 MHz to 115200 baud is N=694, num=4, den=9. This gives the slot sequence 694, 695, 694, 695, 694, 695, 694, 695, 694, and the sequence then repeats.

The tick feeds a serialiser. Dropping the enable input parks the generator and discards any partly counted slot.

Top module: `frac_baud_tick`

## Requirements
- R1: While reset is applied, and on every clock after a cycle in which `en` is low, `tick` is low.
- R2: The first tick after `en` rises comes after L1 clocks, where L1 = N + 1 if floor(den/2) + num >= den and L1 = N otherwise. Clocks are counted as enabled rising edges, and `tick` is high in the cycle after the L1-th such edge.
- R3: Every interval between consecutive ticks lasts either N or N+1 clocks.
- R4: With a valid fraction, the k=den-th tick falls exactly den*N + num clocks after enable, so the long-run rate is exact.
- R5: The k-th tick falls at clock k*N + floor((k*num + floor(den/2)) / den) after enable. Long and short intervals are therefore interleaved, and every tick is within half a clock of its ideal time.
- R6: With `frac_num` = 0, the block is a plain divider that ticks every N clocks.
- R7: A fraction with `frac_den` = 0, or with `frac_num` >= `frac_den`, is ignored, and the period is exactly N.
- R8: A `base_period` of 0 is treated as 1, so the block ticks on every enabled clock.
- R9: When the period is more than one clock, `tick` is high for exactly one cycle per interval.
- R10: Dropping `en` in the middle of an interval discards that interval. After `en` returns, the tick sequence restarts from its first interval, with the same timing as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the counter and accumulator |
| base_period | input | 16 | Whole part N of the bit period, in clocks |
| frac_num | input | 16 | Numerator of the fractional part |
| frac_den | input | 16 | Denominator of the fractional part |
| tick | output | 1 | One-cycle pulse at each bit boundary |

## Verification
The bench runs the generator with the package default of 16-bit period and fraction fields. It drives a range of settings through those fields. The real 694 + 4/9 case runs for two full nine-slot cycles, which exposes the interleaving and the exact average. Small periods down to one clock exercise back-to-back ticks. Both even and odd denominators are used, so that ties in the rounding are exercised. Invalid fractions, with a zero denominator or a numerator at or above the denominator, are also applied, and a mid-interval disable checks that a restart begins again from the first interval.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  parameter int unsigned PERIOD_W = 16;
  parameter int unsigned FRAC_W   = 16;
  localparam int unsigned LEN_W   = PERIOD_W + 1;

  typedef logic [PERIOD_W-1:0] period_t;
  typedef logic [FRAC_W-1:0]   frac_t;
  typedef logic [LEN_W-1:0]    len_t;

  typedef struct packed {
    logic  longer;
    len_t  len;
    frac_t rem;
  } step_t;

  // The fraction is used only when it is a proper fraction.
  function automatic logic frac_ok(frac_t num, frac_t den);
    return (den != '0) && (num < den);
  endfunction

  // Whole period with 0 promoted to 1.
  function automatic len_t base_len(period_t n);
    return (n == '0) ? len_t'(1) : len_t'(n);
  endfunction

  // Starting remainder: half the denominator gives round-to-nearest tick times.
  function automatic frac_t seed_rem(frac_t den);
    return den >> 1;
  endfunction

  // One accumulator step: add the numerator; on reaching den, wrap and lengthen.
  function automatic step_t advance(period_t n, frac_t num, frac_t den, frac_t rem);
    step_t s;
    logic [FRAC_W:0] sum;
    sum = {1'b0, rem} + {1'b0, num};
    if (frac_ok(num, den)) begin
      s.longer = (sum >= {1'b0, den});
      s.rem    = s.longer ? frac_t'(sum - {1'b0, den}) : frac_t'(sum);
    end else begin
      s.longer = 1'b0;
      s.rem    = '0;
    end
    s.len = base_len(n) + len_t'(s.longer);
    return s;
  endfunction

endpackage

// File: rtl/frac_step.sv
module frac_step
  import frac_tick_pkg::*;
(
  input  period_t base_period,
  input  frac_t   frac_num,
  input  frac_t   frac_den,
  input  frac_t   rem_in,
  output step_t   step_out
);

  always_comb step_out = advance(base_period, frac_num, frac_den, rem_in);

endmodule

// File: rtl/tick_interval_counter.sv
module tick_interval_counter
  import frac_tick_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  step_t first_i,
  input  step_t next_i,
  output logic  tick,
  output len_t  cur_len,
  output frac_t cur_rem
);

  logic  armed_q;
  len_t  cnt_q;
  len_t  len_q;
  frac_t rem_q;
  logic  tick_q;
  len_t  cnt_inc;
  logic  wrap;

  // Until armed, the interval in use is the first one computed from the config.
  assign cur_len = armed_q ? len_q : first_i.len;
  assign cur_rem = armed_q ? rem_q : first_i.rem;
  assign cnt_inc = cnt_q + len_t'(1);
  assign wrap    = (cnt_inc == cur_len);
  assign tick    = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      len_q   <= len_t'(1);
      rem_q   <= '0;
      tick_q  <= 1'b0;
    end else if (!en) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      tick_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (wrap) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
        len_q  <= next_i.len;
        rem_q  <= next_i.rem;
      end else begin
        cnt_q  <= cnt_inc;
        tick_q <= 1'b0;
        len_q  <= cur_len;
        rem_q  <= cur_rem;
      end
    end
  end

  // R1: a disabled cycle parks the block with no tick and a cleared count
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick && cnt_q == '0));

  // R9: with a period above one clock, a tick is followed by a low cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_len > len_t'(1)) |=> !tick);

  // R3: the running count never reaches the interval length
  a_r3_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_len);

endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import frac_tick_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] base_period,
  input  logic [FRAC_W-1:0]   frac_num,
  input  logic [FRAC_W-1:0]   frac_den,
  output logic                tick
);

  step_t first_step;
  step_t next_step;
  len_t  cur_len;
  frac_t cur_rem;
  frac_t seed;
  len_t  n_eff;

  assign seed  = seed_rem(frac_den);
  assign n_eff = base_len(base_period);

  // First interval: accumulator starts from its seed.
  frac_step u_first (
    .base_period (base_period),
    .frac_num    (frac_num),
    .frac_den    (frac_den),
    .rem_in      (seed),
    .step_out    (first_step)
  );

  // Following intervals: accumulator continues from the running remainder.
  frac_step u_next (
    .base_period (base_period),
    .frac_num    (frac_num),
    .frac_den    (frac_den),
    .rem_in      (cur_rem),
    .step_out    (next_step)
  );

  tick_interval_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .first_i (first_step),
    .next_i  (next_step),
    .tick    (tick),
    .cur_len (cur_len),
    .cur_rem (cur_rem)
  );

  // R3: the interval loaded at a tick is N or N+1 when the config held still
  a_r3_len_choice: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(base_period) && $stable(frac_num) && $stable(frac_den))
      |-> (cur_len == n_eff || cur_len == n_eff + len_t'(1)));

  // R4: the remainder stays a proper fraction of the denominator
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(frac_num) && $stable(frac_den) && frac_ok(frac_num, frac_den))
      |-> (cur_rem < frac_den));

  // R7: an invalid fraction never yields a long interval
  a_r7_no_long_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(base_period) && $stable(frac_num) && $stable(frac_den)
      && !frac_ok(frac_num, frac_den)) |-> (cur_len == n_eff));

endmodule

// File: tb/frac_baud_tick_bench.sv
module frac_baud_tick_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {N, num, den, ticks, requirement tag number}
  localparam int VEC [NVEC][5] = '{
    '{694, 4, 9, 18, 5},   // R5, R4: 80 MHz to 115200 case, two full cycles
    '{10,  3, 7, 14, 5},   // R5: odd denominator
    '{7,   1, 2,  8, 5},   // R5: even denominator, rounding tie
    '{20,  5, 9,  9, 4},   // R4: first tick of this one is long
    '{3,  15, 16, 16, 3},  // R3: nearly every interval long
    '{5,   0, 9,  6, 6},   // R6: plain divider
    '{6,   9, 9,  5, 7},   // R7: num equal to den
    '{6,   3, 0,  5, 7},   // R7: zero denominator
    '{0,   0, 1,  5, 8},   // R8: period zero treated as one
    '{1,   1, 2,  8, 9}    // R9: periods of one and two clocks
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] base_period = '0;
  logic [15:0] frac_num = '0;
  logic [15:0] frac_den = '0;
  logic        tick;

  int tests = 0;
  int fails = 0;

  frac_baud_tick u_frac_baud_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .base_period (base_period),
    .frac_num    (frac_num),
    .frac_den    (frac_den),
    .tick        (tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ideal tick time rounded to nearest clock, computed directly.
  function automatic int ideal_time(int k, int n, int num, int den);
    int ne, nu, de;
    ne = (n == 0) ? 1 : n;
    if (den == 0 || num >= den) begin nu = 0; de = 1; end
    else begin nu = num; de = den; end
    return k * ne + (k * nu + de / 2) / de;
  endfunction

  task automatic check(bit ok, int req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(int n, int num, int den, int nt, int tag);
    int k, prev, tend, ne;
    bit valid, exp_hi;
    ne = (n == 0) ? 1 : n;
    valid = (den != 0) && (num < den);
    @(negedge clk);
    en = 1'b0;
    base_period = 16'(n); frac_num = 16'(num); frac_den = 16'(den);
    repeat (3) @(negedge clk);
    en = 1'b1;
    k = 0; prev = 0;
    tend = ideal_time(nt, n, num, den);
    for (int e = 1; e <= tend; e++) begin
      @(posedge clk);
      @(negedge clk);
      exp_hi = (e == ideal_time(k + 1, n, num, den));
      if (exp_hi || tick) check(tick == exp_hi, tag, int'(tick), int'(exp_hi)); // R5/R9 timing
      if (tick) begin
        k++;
        check((e - prev) == ne || (e - prev) == ne + 1, 3, e - prev, ne);   // R3
        if (k == 1) check(e == ideal_time(1, n, num, den), 2, e,
                          ideal_time(1, n, num, den));                     // R2
        if (valid && k == den) check(e == den * ne + num, 4, e, den * ne + num); // R4
        prev = e;
      end
    end
    check(k == nt, tag, k, nt);
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    // R1: tick low under reset
    repeat (3) @(negedge clk);
    check(tick == 1'b0, 1, int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, 1, int'(tick), 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

    // R10: disable mid-interval, then restart from the first interval
    @(negedge clk);
    base_period = 16'd12; frac_num = 16'd5; frac_den = 16'd8;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (20) @(negedge clk);   // one tick at 13, now 7 clocks into the next
    en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check(cnt == 0, 1, cnt, 0);   // R1: no tick while disabled
    en = 1'b1;
    cnt = 0;
    for (int e = 1; e <= 13; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (tick && cnt == 0) cnt = e;
    end
    check(cnt == 13, 10, cnt, 13); // R10: first tick timing restarts
    en = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule